// File: doc/BRIEF.md
# Parity-Quantization Watermark Embedder

This block hides a single watermark bit inside one unsigned 16-bit transform coefficient. It divides the coefficient by a programmable quality factor and takes the floor quotient. It then moves that quotient to the nearest value whose parity equals the bit: odd for a one, even for a zero. The adjusted quotient is multiplied back by the quality factor, so the output always sits on a multiple of the quality factor that encodes the bit. A decoder recovers the bit by dividing the coefficient and reading the low bit of the rounded quotient.

The division is done by repeated subtraction, one quotient unit per clock. A single multiplier then rebuilds the coefficient. Requests enter through a valid/ready pair, and results leave through a second valid/ready pair that holds its data under backpressure. A quality factor of zero is refused: the coefficient passes through unchanged and an error flag marks the result. The intended quality factor range is 15 to 35.

Top module: `wm_parity_embed`

## Requirements
- R1: After reset, outValid, busy and outErr are 0 and inReady is 1.
- R2: inReady equals the inverse of busy. An offer on inValid while busy is 0 is accepted at that clock edge. Offers made while busy is 1 are ignored and do not change the pending result.
- R3: For a nonzero quality factor the result has outErr = 0. It is an exact multiple of the quality factor, and its quotient by the quality factor is odd when the bit is 1 and even when the bit is 0.
- R4: With floor quotient q = coef / qf, the result is q*qf when q already has the wanted parity, and (q+1)*qf otherwise, provided that value fits in 16 bits.
- R5: When (q+1)*qf would exceed 65535, the result is (q-1)*qf, which keeps the wanted parity.
- R6: A quality factor of 0 gives outCoef equal to the input coefficient with outErr = 1. outValid rises right after the accepting clock edge.
- R7: For a nonzero quality factor, outValid rises after the (floor(coef/qf)+2)-th rising edge that follows the accepting edge.
- R8: While outValid is 1 and outReady is 0, outValid, outCoef and outErr hold their values.
- R9: busy goes to 1 at the accepting edge. It stays 1 until the edge where outValid and outReady are both 1, and after that edge outValid is 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request offered |
| inReady | output | 1 | Block can accept a request |
| inCoef | input | 16 | Unsigned coefficient to modify |
| inBit | input | 1 | Watermark bit to hide |
| inQf | input | 6 | Quality factor (divisor) |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Downstream takes the result |
| outCoef | output | 16 | Modified coefficient |
| outErr | output | 1 | Quality factor was zero, so the coefficient was passed through |
| busy | output | 1 | A request is in progress or its result is waiting |

## Verification
Two things can happen in the same cycle: a finished result waits under output backpressure, and a new request is offered on the input. The bench holds outReady low for several cycles while it keeps inValid high with a different coefficient. On every stalled cycle it checks that inReady stays 0 and that outCoef does not move. Once the result is released, the bench checks it against the first request only, so an accepted intruder would show up as a wrong value or an extra result.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_MUL  = 2'd2,
    ST_OUT  = 2'd3
  } wmState_t;

  typedef struct packed {
    logic load;  // capture a new request
    logic step;  // one subtraction of the divisor
    logic fix;   // parity adjust and multiply back
  } wmStrobe_t;
endpackage

// File: rtl/wm_embed_dp.sv
module wm_embed_dp
  import wm_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int QF_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  wmStrobe_t         ctl,
  input  logic [COEF_W-1:0] inCoef,
  input  logic              inBit,
  input  logic [QF_W-1:0]   inQf,
  output logic              remGe,
  output logic              qfZero,
  output logic [COEF_W-1:0] outCoef,
  output logic              outErr
);
  localparam int QA_W   = COEF_W + 1;
  localparam int PROD_W = QA_W + QF_W;

  logic [COEF_W-1:0] remR, quoR, coefR;
  logic [QF_W-1:0]   qfR;
  logic              bitR, errR;

  logic [QA_W-1:0]   quoAdj;
  logic [PROD_W-1:0] prod;
  logic              prodOvf;
  logic [COEF_W-1:0] prodBack;

  assign qfZero = (inQf == '0);
  assign remGe  = (remR >= COEF_W'(qfR));

  // move quotient to the wanted parity, then rebuild with one multiplier
  assign quoAdj   = {1'b0, quoR} + QA_W'(quoR[0] ^ bitR);
  assign prod     = PROD_W'(quoAdj) * PROD_W'(qfR);
  assign prodOvf  = |prod[PROD_W-1:COEF_W];
  // two quotient steps down keeps parity and always fits
  assign prodBack = prod[COEF_W-1:0] - COEF_W'({qfR, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      coefR <= '0;
      qfR   <= '0;
      bitR  <= 1'b0;
      errR  <= 1'b0;
    end else if (ctl.load) begin
      remR  <= inCoef;
      quoR  <= '0;
      coefR <= inCoef;
      qfR   <= inQf;
      bitR  <= inBit;
      errR  <= qfZero;
    end else if (ctl.step) begin
      remR <= remR - COEF_W'(qfR);
      quoR <= quoR + 1'b1;
    end else if (ctl.fix) begin
      coefR <= prodOvf ? prodBack : prod[COEF_W-1:0];
    end
  end

  assign outCoef = coefR;
  assign outErr  = errR;
endmodule

// File: rtl/wm_embed_ctrl.sv
module wm_embed_ctrl
  import wm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      outReady,
  input  logic      remGe,
  input  logic      qfZero,
  output wmStrobe_t ctl,
  output logic      inReady,
  output logic      outValid,
  output logic      busy
);
  wmState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: if (inValid) begin
        ctl.load = 1'b1;
        stateNxt = qfZero ? ST_OUT : ST_DIV;
      end
      ST_DIV: begin
        if (remGe) ctl.step = 1'b1;
        else       stateNxt = ST_MUL;
      end
      ST_MUL: begin
        ctl.fix  = 1'b1;
        stateNxt = ST_OUT;
      end
      ST_OUT: if (outReady) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign inReady  = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign outValid = (state == ST_OUT);
endmodule

// File: rtl/wm_parity_embed.sv
module wm_parity_embed
  import wm_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int QF_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [COEF_W-1:0] inCoef,
  input  logic              inBit,
  input  logic [QF_W-1:0]   inQf,
  output logic              outValid,
  input  logic              outReady,
  output logic [COEF_W-1:0] outCoef,
  output logic              outErr,
  output logic              busy
);
  wmStrobe_t ctl;
  logic      remGe, qfZero;

  wm_embed_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .remGe(remGe), .qfZero(qfZero), .ctl(ctl), .inReady(inReady),
    .outValid(outValid), .busy(busy)
  );

  wm_embed_dp #(.COEF_W(COEF_W), .QF_W(QF_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inCoef(inCoef), .inBit(inBit),
    .inQf(inQf), .remGe(remGe), .qfZero(qfZero), .outCoef(outCoef),
    .outErr(outErr)
  );
endmodule

// File: rtl/wm_parity_embed_chk.sv
module wm_parity_embed_chk #(
  parameter int COEF_W = 16,
  parameter int QF_W   = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [COEF_W-1:0] inCoef,
  input logic              inBit,
  input logic [QF_W-1:0]   inQf,
  input logic              outValid,
  input logic              outReady,
  input logic [COEF_W-1:0] outCoef,
  input logic              outErr,
  input logic              busy
);
  logic [COEF_W-1:0] coefCap;
  logic [QF_W-1:0]   qfCap;
  logic              bitCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefCap <= '0;
      qfCap   <= '0;
      bitCap  <= 1'b0;
    end else if (inValid && inReady) begin
      coefCap <= inCoef;
      qfCap   <= inQf;
      bitCap  <= inBit;
    end
  end

  a_r3_parity: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outErr) |-> ((int'(outCoef) % int'(qfCap)) == 0) &&
      (((int'(outCoef) / int'(qfCap)) % 2) == int'(bitCap)));

  // R4 and R5: result stays within one step above or two steps below the coefficient
  a_r4_near: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outErr) |-> (int'(outCoef) <= int'(coefCap) + int'(qfCap)) &&
      (int'(outCoef) + 2 * int'(qfCap) > int'(coefCap)));

  a_r6_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outErr) |-> (outCoef == coefCap) && (qfCap == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outCoef) && $stable(outErr));

  a_r9_busy: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> busy);

  a_r2_ready: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !busy && !outValid);
endmodule

bind wm_parity_embed wm_parity_embed_chk #(.COEF_W(COEF_W), .QF_W(QF_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inCoef(inCoef), .inBit(inBit), .inQf(inQf), .outValid(outValid),
  .outReady(outReady), .outCoef(outCoef), .outErr(outErr), .busy(busy)
);

// File: tb/sim_wm_parity_embed.sv
`timescale 1ns/1ps
module sim_wm_parity_embed;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inCoef = '0;
  logic        inBit = 1'b0;
  logic [5:0]  inQf = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [15:0] outCoef;
  logic        outErr;
  logic        busy;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wm_parity_embed u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCoef(inCoef), .inBit(inBit), .inQf(inQf), .outValid(outValid),
    .outReady(outReady), .outCoef(outCoef), .outErr(outErr), .busy(busy)
  );

  function automatic int expCoef(int c, int b, int q);
    int qt, qa;
    if (q == 0) return c;
    qt = c / q;
    qa = ((qt % 2) == b) ? qt : qt + 1;
    if (qa * q > 65535) qa = qa - 2;
    return qa * q;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOne(int c, int b, int q, int stall);
    int cnt, expLat;
    @(negedge clk);
    check(inReady == 1'b1 && busy == 1'b0, "R2 ready before offer", inReady, 1);
    inValid = 1'b1;
    inCoef  = 16'(c);
    inBit   = 1'(b);
    inQf    = 6'(q);
    @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    // keep offering a different request while busy: must be ignored
    inValid = (stall > 0);
    inCoef  = ~16'(c);
    inBit   = ~1'(b);
    cnt = 0;
    while (!outValid && cnt < 70000) begin
      if (inReady) check(0, "R2 ready while busy", inReady, 0);
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    expLat = (q == 0) ? 0 : (c / q) + 2;
    check(cnt == expLat, (q == 0) ? "R6 latency" : "R7 latency", cnt, expLat);
    check(int'(outCoef) == expCoef(c, b, q), (q == 0) ? "R6 passthrough" : "R3 R4 R5 value",
          int'(outCoef), expCoef(c, b, q));
    check(outErr == (q == 0), (q == 0) ? "R6 err flag" : "R3 err clear", outErr, int'(q == 0));
    for (int k = 0; k < stall; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(outValid && int'(outCoef) == expCoef(c, b, q), "R8 hold under stall",
            int'(outCoef), expCoef(c, b, q));
      check(!inReady, "R2 ignore while stalled", inReady, 0);
    end
    inValid  = 1'b0;
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    outReady = 1'b0;
    check(!outValid && inReady && !busy, "R9 release", outValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int seed, c, b, q;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!outValid && inReady && !busy && !outErr, "R1 reset state", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && inReady && !busy && !outErr, "R1 after release", busy, 0);

    // directed corners
    runOne(0, 0, 15, 0);        // R4 zero stays zero
    runOne(0, 1, 15, 0);        // R4 zero moves up to qf
    runOne(30, 0, 15, 0);       // R4 exact even multiple
    runOne(45, 0, 15, 2);       // R4 odd quotient moved up
    runOne(65535, 0, 15, 0);    // R5 overflow step down
    runOne(65535, 1, 35, 3);    // R5 overflow step down, qf 35
    runOne(65535, 0, 35, 0);    // R4 top without overflow
    runOne(1234, 1, 0, 2);      // R6 zero quality factor
    runOne(14, 1, 15, 0);       // R4 coef below qf
    runOne(34, 0, 35, 1);       // R4 coef below qf, even

    // constrained random
    for (int i = 0; i < 30; i++) begin
      c = int'($urandom_range(0, 65535));
      b = int'($urandom_range(0, 1));
      q = int'($urandom_range(15, 35));
      runOne(c, b, q, int'($urandom_range(0, 3)));
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule